// File: doc/BRIEF.md
# Audio codec power-down controller

This block holds the power-down control register of a mixed-signal audio device and turns it into one power-enable line per circuit domain. A host writes and reads the 8-bit register over a small synchronous register bus. Each bit turns off one domain. Some bits also turn off other domains that depend on them. The FM synthesizer follows the DAC path, the mixer follows the voltage reference, and the global bit turns everything off.

The block also sequences two events around the global bit. When the global bit is released, the block issues a full calibration request and holds a busy flag until the calibration engine answers. The embedded processor is not woken at that point. It is woken by a host access to one of its legacy interfaces (plug-and-play, MIDI or game-audio), or by a second write of zero to the global bit. The block also produces two flags. The first forces the mixer into bypass when the mixer is down but the reference is still up. The second reports that the sample-rate converters are down, and it marks any sample-rate request other than 44.1 kHz as invalid.

Top module: `pwr_ctl_top`

## Requirements
- R1: After reset the register reads 0x00. Every domain enable and the mono-pair enable are 1. The mixer bypass, calibration request, calibration busy, rate-locked and rate-invalid outputs are 0.
- R2: A write with `host_addr` equal to `PD_ADDR` (default 0x02) stores `host_wdata`. A read at that address returns the stored byte on `host_rdata` in the cycle after the read strobe. A write to any other address changes nothing, and a read at any other address returns 0x00.
- R3: The register bits are: bit 7 global, bit 6 SRC, bit 5 VREF, bit 4 MIX, bit 3 ADC, bit 2 DAC, bit 1 processor idle, bit 0 FM. `dom_en` uses the same bit positions. Each enable is 1 only when its own bit, the global bit and its parent bit are all 0. The parent of FM is DAC and the parent of MIX is VREF. The enables take their new value at the clock edge that samples the write.
- R4: `mono_en` (the mono in/out pair) is 1 exactly when both VREF and global are 0, whatever the MIX bit is.
- R5: `mix_bypass` equals `mix_bypass_req` OR (MIX = 1 AND VREF = 0). It is registered on every clock edge.
- R6: `rate_locked` is the stored SRC bit. A `rate_req` strobe with `rate_is_44k1` = 0 while SRC is set gives a one-cycle `rate_invalid` pulse in the next cycle. Any other request gives no pulse.
- R7: While the global bit is set, the register can still be written and read. The other seven bits keep the values written.
- R8: A write that changes the global bit from 1 to 0 gives a `cal_req` pulse exactly one cycle long and sets `cal_busy`. `cal_busy` stays 1 until `cal_done` is seen. A `cal_done` while not busy has no effect.
- R9: A write with bit 1 set puts the processor into idle, which drives `dom_en[1]` to 0. A `legacy_access` pulse wakes the processor without changing the stored register. If the pulse comes in the same cycle as such a write, the pulse wins.
- R10: A write that clears the global bit leaves the processor idle. A later write with global = 0 while the global bit is already 0, and with bit 1 = 0, wakes the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| legacy_access | input | 1 | Pulse: host touched a processor-served interface |
| mix_bypass_req | input | 1 | Mixer bypass value from its own configuration |
| rate_req | input | 1 | Sample-rate request strobe |
| rate_is_44k1 | input | 1 | The requested rate is 44.1 kHz |
| cal_done | input | 1 | Calibration engine finished |
| dom_en | output | 8 | Per-domain power enables, bit order as the register |
| mono_en | output | 1 | Mono in/out pair enable |
| mix_bypass | output | 1 | Effective mixer bypass |
| rate_locked | output | 1 | Converters down, only 44.1 kHz allowed |
| rate_invalid | output | 1 | Pulse: rejected rate request |
| cal_req | output | 1 | Pulse: start full calibration |
| cal_busy | output | 1 | Calibration outstanding |

## Verification
The processor enable is the hardest output to steer, because it depends on the history of writes as well as on the current byte. Its value depends on whether the global bit has just fallen, whether zero was written twice, and whether a legacy access arrived during the write. The bench sweeps all 256 register values in order and keeps its own model of the idle state alongside. It then drives directed sequences: a global release followed by a second zero write, and a legacy pulse in the same cycle as a write that sets the idle bit.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

    localparam int NDOM = 8;

    localparam int B_FM   = 0;
    localparam int B_PROC = 1;
    localparam int B_DAC  = 2;
    localparam int B_ADC  = 3;
    localparam int B_MIX  = 4;
    localparam int B_VREF = 5;
    localparam int B_SRC  = 6;
    localparam int B_GLB  = 7;

    typedef struct packed {
        logic glb;
        logic src;
        logic vref;
        logic mix;
        logic adc;
        logic dac;
        logic prc;
        logic fm;
    } pd_reg_t;

    // Events decoded from one host write, consumed by the sequencer
    typedef struct packed {
        logic hit;        // write to the power-down register
        logic glb_fall;   // global bit 1 -> 0
        logic glb_again;  // global written 0 while already 0
        logic idle_bit;   // written processor-idle bit
    } wr_evt_t;

    // Register bits that switch a domain off (own, parent, global)
    function automatic logic [NDOM-1:0] dom_mask(input int idx);
        logic [NDOM-1:0] m;
        m = '0;
        m[B_GLB] = 1'b1;
        m[idx]   = 1'b1;
        if (idx == B_FM)  m[B_DAC]  = 1'b1;
        if (idx == B_MIX) m[B_VREF] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
    import pwr_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PD_ADDR = 'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NDOM-1:0]   wdata,
    output pd_reg_t           reg_q,
    output pd_reg_t           reg_d,
    output wr_evt_t           evt,
    output logic [NDOM-1:0]   rdata
);

    logic    sel;
    pd_reg_t wpd;

    assign sel = (addr == PD_ADDR);
    assign wpd = pd_reg_t'(wdata);

    always_comb begin
        reg_d = reg_q;
        if (wr && sel) reg_d = wpd;
    end

    always_comb begin
        evt.hit       = wr && sel;
        evt.glb_fall  = wr && sel && reg_q.glb && !wpd.glb;
        evt.glb_again = wr && sel && !reg_q.glb && !wpd.glb;
        evt.idle_bit  = wpd.prc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            rdata <= '0;
        end else begin
            reg_q <= reg_d;
            rdata <= (rd && sel) ? NDOM'(reg_q) : '0;
        end
    end

endmodule

// File: rtl/pwr_ctl_seq.sv
module pwr_ctl_seq
    import pwr_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_evt_t evt,
    input  logic    legacy_access,
    input  logic    cal_done,
    output logic    idle_d,
    output logic    cal_req,
    output logic    cal_busy
);

    logic idle_q;

    always_comb begin
        idle_d = idle_q;
        if (evt.hit) begin
            if (evt.idle_bit)       idle_d = 1'b1;
            else if (evt.glb_fall)  idle_d = 1'b1;
            else if (evt.glb_again) idle_d = 1'b0;
        end
        if (legacy_access) idle_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q   <= 1'b0;
            cal_req  <= 1'b0;
            cal_busy <= 1'b0;
        end else begin
            idle_q   <= idle_d;
            cal_req  <= evt.glb_fall;
            cal_busy <= evt.glb_fall || (cal_busy && !cal_done);
        end
    end

endmodule

// File: rtl/pwr_ctl_domains.sv
module pwr_ctl_domains
    import pwr_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pd_reg_t         reg_d,
    input  pd_reg_t         reg_q,
    input  logic            idle_d,
    input  logic            mix_bypass_req,
    input  logic            rate_req,
    input  logic            rate_is_44k1,
    output logic [NDOM-1:0] dom_en,
    output logic            mono_en,
    output logic            mix_bypass,
    output logic            rate_locked,
    output logic            rate_invalid
);

    logic [NDOM-1:0] rbits;
    logic [NDOM-1:0] en_d;

    assign rbits = NDOM'(reg_d);

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        if (i == B_PROC) begin : g_proc
            assign en_d[i] = !rbits[B_GLB] && !idle_d;
        end else begin : g_plain
            assign en_d[i] = ~|(rbits & dom_mask(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dom_en       <= '1;
            mono_en      <= 1'b1;
            mix_bypass   <= 1'b0;
            rate_locked  <= 1'b0;
            rate_invalid <= 1'b0;
        end else begin
            dom_en       <= en_d;
            mono_en      <= !reg_d.glb && !reg_d.vref;
            mix_bypass   <= mix_bypass_req || (reg_d.mix && !reg_d.vref);
            rate_locked  <= reg_d.src;
            rate_invalid <= rate_req && !rate_is_44k1 && reg_q.src;
        end
    end

endmodule

// File: rtl/pwr_ctl_top.sv
module pwr_ctl_top
    import pwr_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PD_ADDR = 'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              legacy_access,
    input  logic              mix_bypass_req,
    input  logic              rate_req,
    input  logic              rate_is_44k1,
    input  logic              cal_done,
    output logic [7:0]        dom_en,
    output logic              mono_en,
    output logic              mix_bypass,
    output logic              rate_locked,
    output logic              rate_invalid,
    output logic              cal_req,
    output logic              cal_busy
);

    pd_reg_t reg_q;
    pd_reg_t reg_d;
    wr_evt_t evt;
    logic    idle_d;

    pwr_ctl_regs #(.ADDR_W(ADDR_W), .PD_ADDR(PD_ADDR)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (host_wr),
        .rd    (host_rd),
        .addr  (host_addr),
        .wdata (host_wdata),
        .reg_q (reg_q),
        .reg_d (reg_d),
        .evt   (evt),
        .rdata (host_rdata)
    );

    pwr_ctl_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .legacy_access (legacy_access),
        .cal_done      (cal_done),
        .idle_d        (idle_d),
        .cal_req       (cal_req),
        .cal_busy      (cal_busy)
    );

    pwr_ctl_domains u_dom (
        .clk            (clk),
        .rst            (rst),
        .reg_d          (reg_d),
        .reg_q          (reg_q),
        .idle_d         (idle_d),
        .mix_bypass_req (mix_bypass_req),
        .rate_req       (rate_req),
        .rate_is_44k1   (rate_is_44k1),
        .dom_en         (dom_en),
        .mono_en        (mono_en),
        .mix_bypass     (mix_bypass),
        .rate_locked    (rate_locked),
        .rate_invalid   (rate_invalid)
    );

endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       legacy_access,
    input logic       cal_done,
    input logic [7:0] dom_en,
    input logic       mono_en,
    input logic       rate_locked,
    input logic       rate_invalid,
    input logic       cal_req,
    input logic       cal_busy
);

    p_cal_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        cal_req |=> !cal_req);

    p_cal_busy_r8: assert property (@(posedge clk) disable iff (rst)
        cal_req |-> cal_busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && !cal_done && !cal_req) |=> cal_busy);

    p_glb_off_r3: assert property (@(posedge clk) disable iff (rst)
        !dom_en[7] |-> (dom_en == 8'h00 && !mono_en));

    p_fm_parent_r3: assert property (@(posedge clk) disable iff (rst)
        dom_en[0] |-> dom_en[2]);

    p_mix_mono_r4: assert property (@(posedge clk) disable iff (rst)
        dom_en[4] |-> (mono_en && dom_en[5]));

    p_wake_r9: assert property (@(posedge clk) disable iff (rst)
        legacy_access |=> (dom_en[1] == dom_en[7]));

    p_rate_r6: assert property (@(posedge clk) disable iff (rst)
        rate_invalid |-> $past(rate_locked));

endmodule

bind pwr_ctl_top pwr_ctl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .legacy_access (legacy_access),
    .cal_done      (cal_done),
    .dom_en        (dom_en),
    .mono_en       (mono_en),
    .rate_locked   (rate_locked),
    .rate_invalid  (rate_invalid),
    .cal_req       (cal_req),
    .cal_busy      (cal_busy)
);

// File: tb/pwr_ctl_top_tb.sv
module pwr_ctl_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PDA = 8'h02;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic       legacy_access = 1'b0, mix_bypass_req = 1'b0;
    logic       rate_req = 1'b0, rate_is_44k1 = 1'b0, cal_done = 1'b0;
    logic [7:0] dom_en;
    logic       mono_en, mix_bypass, rate_locked, rate_invalid, cal_req, cal_busy;

    int n_chk = 0;
    int n_fail = 0;
    logic m_idle = 1'b0;
    logic [7:0] m_reg = 8'h00;

    pwr_ctl_top u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .legacy_access(legacy_access), .mix_bypass_req(mix_bypass_req),
        .rate_req(rate_req), .rate_is_44k1(rate_is_44k1), .cal_done(cal_done),
        .dom_en(dom_en), .mono_en(mono_en), .mix_bypass(mix_bypass),
        .rate_locked(rate_locked), .rate_invalid(rate_invalid),
        .cal_req(cal_req), .cal_busy(cal_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_en(input logic [7:0] r, input logic idle);
        logic g;
        logic [7:0] e;
        g = r[7];
        e[0] = !(g | r[2] | r[0]);
        e[1] = !(g | idle);
        e[2] = !(g | r[2]);
        e[3] = !(g | r[3]);
        e[4] = !(g | r[5] | r[4]);
        e[5] = !(g | r[5]);
        e[6] = !(g | r[6]);
        e[7] = !g;
        return e;
    endfunction

    // Writes, then samples at the following falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic leg);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; legacy_access = leg;
        if (a == PDA) begin
            if (d[1]) m_idle = 1'b1;
            else if (m_reg[7] && !d[7]) m_idle = 1'b1;
            else if (!m_reg[7] && !d[7]) m_idle = 1'b0;
            m_reg = d;
        end
        if (leg) m_idle = 1'b0;
        @(negedge clk);
        host_wr = 1'b0; legacy_access = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 dom_en", dom_en, 8'hFF);
        check("R1 mono", mono_en, 1);
        check("R1 bypass", mix_bypass, 0);
        check("R1 cal", {cal_req, cal_busy, rate_locked, rate_invalid}, 0);
        rd(PDA, v);
        check("R1 reg", v, 8'h00);

        // Sweep all register values: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            mix_bypass_req = ^b;
            wr(PDA, b, 1'b0);
            check("R3 enables", dom_en, exp_en(b, m_idle));
            check("R4 mono", mono_en, !b[7] && !b[5]);
            check("R5 bypass", mix_bypass, (^b) | (b[4] & !b[5]));
            check("R6 locked", rate_locked, b[6]);
            rd(PDA, v);
            check(b[7] ? "R7 readback" : "R2 readback", v, b);
        end
        mix_bypass_req = 1'b0;

        // R2 other address ignored
        wr(8'h03, 8'h00, 1'b0);
        rd(PDA, v);
        check("R2 foreign write", v, 8'hFF);
        rd(8'h03, v);
        check("R2 foreign read", v, 8'h00);

        // R7 writes while globally down keep other bits
        wr(PDA, 8'h95, 1'b0);
        rd(PDA, v);
        check("R7 keep", v, 8'h95);
        check("R7 all off", dom_en, 8'h00);

        // R8 R10 release global
        wr(PDA, 8'h00, 1'b0);
        check("R8 cal_req", cal_req, 1);
        check("R8 busy", cal_busy, 1);
        check("R10 still idle", dom_en[1], 0);
        check("R10 others on", dom_en, 8'hFD);
        @(negedge clk);
        check("R8 pulse end", cal_req, 0);
        check("R8 busy hold", cal_busy, 1);
        wr(PDA, 8'h00, 1'b0);
        check("R10 second zero wakes", dom_en[1], 1);
        check("R8 no second req", cal_req, 0);
        @(negedge clk); cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        check("R8 busy clear", cal_busy, 0);
        @(negedge clk); cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        check("R8 stray done", {cal_busy, cal_req}, 0);

        // R9 idle and legacy wake
        wr(PDA, 8'h02, 1'b0);
        check("R9 idle", dom_en[1], 0);
        @(negedge clk); legacy_access = 1'b1;
        @(negedge clk); legacy_access = 1'b0;
        check("R9 wake", dom_en[1], 1);
        rd(PDA, v);
        check("R9 reg unchanged", v, 8'h02);
        wr(PDA, 8'h06, 1'b1);
        check("R9 legacy wins", dom_en[1], m_idle ? 0 : 1);
        check("R9 legacy wins abs", dom_en[1], 1);

        // R6 rate requests
        wr(PDA, 8'h40, 1'b0);
        @(negedge clk); rate_req = 1'b1; rate_is_44k1 = 1'b0;
        @(negedge clk); rate_req = 1'b0;
        check("R6 invalid", rate_invalid, 1);
        @(negedge clk);
        check("R6 one cycle", rate_invalid, 0);
        rate_req = 1'b1; rate_is_44k1 = 1'b1;
        @(negedge clk); rate_req = 1'b0;
        check("R6 44k1 ok", rate_invalid, 0);
        wr(PDA, 8'h00, 1'b0);
        @(negedge clk); rate_req = 1'b1; rate_is_44k1 = 1'b0;
        @(negedge clk); rate_req = 1'b0;
        check("R6 unlocked", rate_invalid, 0);

        finish_run();
    end

endmodule